// File: doc/BRIEF.md
# HDLC Transmit Bit Formatter

This block turns a stream of frame bytes into a bit-serial HDLC line signal for a single channel. Bytes arrive on a valid/ready interface, with a start marker on the first byte of a frame and an end marker on the last. The block sends one line bit each time `bit_en` is high. It wraps every frame in flag octets, inserts a zero after every run of five ones, appends a complemented frame check sequence, and emits an abort on command or when the byte source runs dry mid-frame.

Each frame latches its check mode when it starts. The mode is either CRC-16 or CRC-32, or a pass-through setting in which the byte stream goes out unchanged with no check sequence added. Between frames the line carries either continuous ones or repeated flags. A configurable number of extra flags can follow each closing flag so that the bit rate can be padded. When the next frame is already waiting and no padding is asked for, a single flag both closes one frame and opens the next. A global option inverts every bit on the line.

The block is meant to sit behind a per-channel context store and a time-slot mapper, which supply `bit_en` at the slot rate.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Every frame is preceded and followed by the flag octet 0x7E. On the line it reads 0,1,1,1,1,1,1,0.
- R2: When `cfg_gap` is 0 and a byte marked with `in_sof` is waiting as a closing flag completes, exactly one flag separates the two frames.
- R3: Within frame content and FCS, a 0 is sent after every five consecutive 1s. This also applies to the last bits before the closing flag.
- R4: With `cfg_crc32`=0 the FCS is CRC-16. It uses x^16+x^12+x^5+1, bit-reflected 0x8408, starting from all ones. With `cfg_crc32`=1 it is CRC-32, reflected 0xEDB88320, starting from all ones. Either FCS is sent complemented, least-significant bit first, after the last byte. The mode is latched with the first byte of each frame.
- R5: With `cfg_crc_pass`=1 at frame start, no FCS is appended and the bytes are sent exactly as supplied.
- R6: `abort_req`, seen on a `bit_en` clock inside a frame, drops the frame and sends eight 1s, after which the line idles. Bytes without `in_sof` that arrive while idle are accepted and discarded. Outside a frame, `abort_req` has no effect.
- R7: After each closing flag, `cfg_gap` extra flags are sent, so back-to-back frames are separated by `cfg_gap`+1 flags.
- R8: While idle, the line carries all 1s when `cfg_fill_ones`=1 and repeated flags when it is 0.
- R9: With `cfg_invert`=1, every line bit, fill included, is inverted.
- R10: If no byte is offered when a non-final byte finishes inside a frame, the frame is aborted as in R6 and `underrun` is high for one clock.
- R11: `tx_bit` changes only on clocks where `bit_en` is high. After reset it is 1.
- R12: A byte is accepted on a clock with `in_valid` and `in_ready` both high. Bytes are sent least-significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One line bit is produced on each clock where this is high |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte is taken this clock |
| cfg_crc32 | input | 1 | 1 selects CRC-32, 0 selects CRC-16 |
| cfg_crc_pass | input | 1 | Send no FCS |
| cfg_invert | input | 1 | Invert line output |
| cfg_fill_ones | input | 1 | Idle fill is ones (1) or flags (0) |
| cfg_gap | input | GAP_W | Extra flags after each closing flag |
| abort_req | input | 1 | Abort the current frame |
| tx_bit | output | 1 | Serial line bit |
| underrun | output | 1 | One-clock pulse on mid-frame byte underrun |

## Verification
The bench builds the block with the default `GAP_W` of 4. It drives `cfg_gap` to 0 and 2, which reaches both the shared-flag handoff and the padded gap. A bit-level receiver model in the bench removes stuffing, finds flags and aborts, and compares the decoded frames and FCS against a queue of expected bytes. Line bits arrive every fourth clock. That spacing leaves room for a byte to be withheld long enough to cause an underrun, and for an abort to land in the middle of a byte.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             in_ready,
  input  logic             cfg_crc32,
  input  logic             cfg_crc_pass,
  input  logic             cfg_invert,
  input  logic             cfg_fill_ones,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             abort_req,
  output logic             tx_bit,
  output logic             underrun
);
  localparam logic [7:0]  FLAG   = 8'h7E;
  localparam logic [31:0] POLY32 = 32'hEDB88320;
  localparam logic [31:0] POLY16 = 32'h00008408;

  typedef enum logic [2:0] {S_IDLE, S_FLAG, S_DATA, S_FCS, S_ABORT} st_t;

  st_t              st;
  logic [31:0]      sh, crc, crc_nx;
  logic [4:0]       cnt;
  logic [2:0]       ones;
  logic             last, c32, pass, raw;
  logic [GAP_W-1:0] gap_left;

  wire in_frame  = (st == S_DATA) || (st == S_FCS);
  wire stuff     = (ones == 3'd5) && (in_frame || st == S_FLAG);
  wire do_abort  = in_frame && abort_req;
  wire byte_end  = (st == S_DATA) && !stuff && (cnt == 5'd7);
  wire flag_end  = (st == S_FLAG) && !stuff && (cnt == 5'd7);
  wire want_byte = (byte_end && !last) || (flag_end && gap_left == '0 && in_sof);
  wire fb        = crc[0] ^ sh[0];
  wire [4:0] fcs_last = c32 ? 5'd31 : 5'd15;

  assign crc_nx   = (crc >> 1) ^ (fb ? (c32 ? POLY32 : POLY16) : 32'h0);
  assign in_ready = (st == S_IDLE && in_valid && !in_sof) ||
                    (bit_en && !do_abort && in_valid && want_byte);

  always_comb begin
    case (st)
      S_IDLE:  raw = cfg_fill_ones | FLAG[cnt[2:0]];
      S_FLAG:  raw = stuff ? 1'b0 : FLAG[cnt[2:0]];
      S_DATA,
      S_FCS:   raw = do_abort ? 1'b1 : (stuff ? 1'b0 : sh[0]);
      default: raw = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tx_bit   <= 1'b1;
      sh       <= '0;
      crc      <= '1;
      cnt      <= '0;
      ones     <= '0;
      last     <= 1'b0;
      c32      <= 1'b0;
      pass     <= 1'b0;
      gap_left <= '0;
      underrun <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (bit_en) begin
        tx_bit <= raw ^ cfg_invert;
        case (st)
          S_IDLE: begin
            cnt <= {2'b00, cnt[2:0] + 3'd1};
            if (in_valid && in_sof && (cfg_fill_ones || cnt[2:0] == 3'd7)) begin
              st       <= S_FLAG;
              cnt      <= '0;
              ones     <= '0;
              gap_left <= '0;
            end
          end
          S_FLAG: begin
            ones <= '0;
            if (!stuff) begin
              if (cnt == 5'd7) begin
                cnt <= '0;
                if (gap_left != '0) begin
                  gap_left <= gap_left - GAP_W'(1);
                end else if (in_valid && in_sof) begin
                  st   <= S_DATA;
                  sh   <= {24'b0, in_data};
                  last <= in_eof;
                  c32  <= cfg_crc32;
                  pass <= cfg_crc_pass;
                  crc  <= cfg_crc32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                cnt <= cnt + 5'd1;
              end
            end
          end
          S_DATA, S_FCS: begin
            if (do_abort) begin
              st  <= S_ABORT;
              cnt <= '0;
            end else if (stuff) begin
              ones <= '0;
            end else begin
              ones <= sh[0] ? ones + 3'd1 : 3'd0;
              sh   <= sh >> 1;
              cnt  <= cnt + 5'd1;
              if (st == S_DATA) begin
                if (!pass) crc <= crc_nx;
                if (cnt == 5'd7) begin
                  cnt <= '0;
                  if (last) begin
                    if (pass) begin
                      st       <= S_FLAG;
                      gap_left <= cfg_gap;
                    end else begin
                      st <= S_FCS;
                      sh <= ~crc_nx;
                    end
                  end else if (in_valid) begin
                    sh   <= {24'b0, in_data};
                    last <= in_eof;
                  end else begin
                    st       <= S_ABORT;
                    underrun <= 1'b1;
                  end
                end
              end else if (cnt == fcs_last) begin
                st       <= S_FLAG;
                cnt      <= '0;
                gap_left <= cfg_gap;
              end
            end
          end
          default: begin
            ones <= '0;
            if (cnt == 5'd7) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 5'd1;
            end
          end
        endcase
      end
    end
  end

  p_stuff_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff && !do_abort) |=> (tx_bit == $past(cfg_invert)));

  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |-> (ones <= 3'd5));

  p_abort_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && st == S_ABORT) |=> (tx_bit != $past(cfg_invert)));

  p_underrun_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (st == S_ABORT));

  p_paced_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  p_take_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);
endmodule

// File: tb/tb_hdlc_tx_framer.sv
module tb_hdlc_tx_framer;
  logic clk = 0, rst_n = 0, bit_en = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic cfg_crc32 = 0, cfg_crc_pass = 0, cfg_invert = 0, cfg_fill_ones = 1, abort_req = 0;
  logic [3:0] cfg_gap = 0;
  logic in_ready, tx_bit, underrun;

  hdlc_tx_framer #(.GAP_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready), .cfg_crc32(cfg_crc32),
    .cfg_crc_pass(cfg_crc_pass), .cfg_invert(cfg_invert), .cfg_fill_ones(cfg_fill_ones),
    .cfg_gap(cfg_gap), .abort_req(abort_req), .tx_bit(tx_bit), .underrun(underrun));

  always #2 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int exp_q[$];
  bit bq[$];
  int ones = 0, flags_since = 0, flags_total = 0, last_gap = 0, aborts = 0, uruns = 0;
  string cur_req = "R1";
  logic en_prev = 0, inv_prev = 0, tx_prev = 1;
  logic [1:0] div = 0;
  bit run_en = 0;
  logic [7:0] pay [16];

  task automatic check(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    #1;
    div = div + 2'd1;
    bit_en = run_en && (div == 2'd0);
  end

  task automatic frame_done();
    int nb;
    nb = bq.size() / 8;
    check(bq.size() % 8 == 0, cur_req, bq.size(), nb * 8);
    for (int i = 0; i < nb; i++) begin
      int v, e;
      v = 0;
      for (int k = 0; k < 8; k++) v = v | (int'(bq[i*8+k]) << k);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : -9;
      check(v == e, cur_req, v, e);
    end
    begin
      int t;
      t = (exp_q.size() > 0) ? exp_q.pop_front() : -9;
      check(t == -1, cur_req, t, -1);
    end
    last_gap = flags_since;
    flags_since = 0;
  endtask

  task automatic rx_bit(bit b);
    if (ones == 5 && !b) begin
      ones = 0;
      return;
    end
    if (ones == 6 && !b) begin
      for (int k = 0; k < 7; k++) if (bq.size() > 0) void'(bq.pop_back());
      if (bq.size() >= 16) frame_done();
      bq.delete();
      flags_since++;
      flags_total++;
      ones = 0;
      return;
    end
    if (b) begin
      ones++;
      if (ones == 7) begin
        if (bq.size() > 8) begin
          int t;
          aborts++;
          t = (exp_q.size() > 0) ? exp_q.pop_front() : -9;
          check(t == -2, cur_req, t, -2);
        end
        bq.delete();
      end
      if (ones < 7) bq.push_back(1'b1);
    end else begin
      ones = 0;
      bq.push_back(1'b0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (underrun) uruns++;
      if (en_prev) rx_bit(tx_bit ^ inv_prev);
      else check(tx_bit === tx_prev, "R11", tx_bit, tx_prev);
    end
    tx_prev = tx_bit;
    en_prev = bit_en;
    inv_prev = cfg_invert;
  end

  function automatic int unsigned calc_fcs(int n, bit c32);
    logic [31:0] c;
    c = c32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        bit f;
        f = c[0] ^ pay[i][k];
        c = c >> 1;
        if (f) c = c ^ (c32 ? 32'hEDB88320 : 32'h00008408);
      end
    return ~c;
  endfunction

  task automatic put_byte(logic [7:0] d, bit s, bit e);
    in_valid = 1; in_data = d; in_sof = s; in_eof = e;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic send_frame(int n);
    int unsigned f;
    for (int i = 0; i < n; i++) exp_q.push_back(int'(pay[i]));
    if (!cfg_crc_pass) begin
      f = calc_fcs(n, cfg_crc32);
      for (int i = 0; i < (cfg_crc32 ? 4 : 2); i++) exp_q.push_back(int'((f >> (8*i)) & 32'hFF));
    end
    exp_q.push_back(-1);
    for (int i = 0; i < n; i++) put_byte(pay[i], i == 0, i == n - 1);
  endtask

  task automatic wait_bits(int n);
    repeat (n * 4) @(posedge clk);
    #1;
  endtask

  task automatic sample_line(logic expv, string req);
    for (int i = 0; i < 6; i++) begin
      repeat (4) @(negedge clk);
      check(tx_bit == expv, req, tx_bit, expv);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 150000);
    check(0, "WATCHDOG", 0, 1);
    finish_up();
  end

  initial begin
    int a0, f0, u0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(tx_bit == 1'b1, "R11", tx_bit, 1);
    check(in_ready == 1'b0, "R12", in_ready, 0);
    @(posedge clk); #1;
    rst_n = 1; run_en = 1;
    wait_bits(20);

    cur_req = "R3";
    pay[0] = 8'h7E; pay[1] = 8'hFF; pay[2] = 8'h01; pay[3] = 8'hF8; pay[4] = 8'h3F;
    send_frame(5); wait_bits(80);
    check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    check(flags_total >= 2, "R1", flags_total, 2);

    cur_req = "R4 R12"; cfg_crc32 = 1;
    pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56; pay[3] = 8'h78; pay[4] = 8'h9A; pay[5] = 8'hBC;
    send_frame(6); wait_bits(100);
    check(exp_q.size() == 0, "R4", exp_q.size(), 0);
    cfg_crc32 = 0;

    cur_req = "R5"; cfg_crc_pass = 1;
    pay[0] = 8'hFE; pay[1] = 8'hFF; pay[2] = 8'h7E;
    send_frame(3); wait_bits(60);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    cfg_crc_pass = 0;

    cur_req = "R2"; cfg_gap = 0;
    pay[0] = 8'hA1; pay[1] = 8'h5C; pay[2] = 8'h33;
    send_frame(3); send_frame(3); wait_bits(80);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    check(last_gap == 1, "R2", last_gap, 1);

    cur_req = "R7"; cfg_gap = 2;
    send_frame(3); send_frame(3); wait_bits(100);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    check(last_gap == 3, "R7", last_gap, 3);
    cfg_gap = 0;

    sample_line(1'b1, "R8");
    cfg_fill_ones = 0;
    f0 = flags_total; wait_bits(48);
    check(flags_total - f0 >= 4, "R8", flags_total - f0, 4);

    cur_req = "R6";
    a0 = aborts; f0 = flags_total;
    abort_req = 1; wait_bits(8); abort_req = 0; wait_bits(24);
    check(aborts == a0, "R6", aborts, a0);
    check(flags_total - f0 >= 3, "R6", flags_total - f0, 3);

    exp_q.push_back(-2);
    put_byte(8'hA5, 1, 0); put_byte(8'h11, 0, 0);
    repeat (2) @(posedge clk); #1;
    abort_req = 1; repeat (8) @(posedge clk); #1; abort_req = 0;
    put_byte(8'h22, 0, 0); put_byte(8'h44, 0, 1);
    wait_bits(40);
    check(aborts == a0 + 1, "R6", aborts, a0 + 1);
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);

    pay[0] = 8'h0F; pay[1] = 8'hF0;
    send_frame(2); wait_bits(60);
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);

    cur_req = "R10";
    u0 = uruns; a0 = aborts;
    exp_q.push_back(-2);
    put_byte(8'h5A, 1, 0);
    wait_bits(50);
    check(uruns == u0 + 1, "R10", uruns, u0 + 1);
    check(aborts == a0 + 1, "R10", aborts, a0 + 1);
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);

    cur_req = "R9";
    cfg_fill_ones = 1; wait_bits(20);
    cfg_invert = 1; wait_bits(4);
    sample_line(1'b0, "R9");
    pay[0] = 8'hC3; pay[1] = 8'h3C; pay[2] = 8'hFF;
    send_frame(3); wait_bits(70);
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);

    finish_up();
  end
endmodule